// File: doc/BRIEF.md
# Partial Two-Channel Interleave Mapper

This block turns a flat physical byte address into a channel choice and a channel-local address for a memory system with two channels of possibly unequal size. The capacity of each channel is given on configuration inputs, in units of 64-byte blocks. Over the low part of the address space both channels hold memory, and there successive 64-byte blocks alternate between channel 0 and channel 1. Above that point only the larger channel still has memory, and every block there goes to it with no alternation. Interleaving is therefore partial: equal sizes interleave everything, unequal sizes give an interleaved base plus a one-channel top, and a zero-size channel leaves the whole range to the other.

A request is an address qualified by a strobe. The result gives a per-channel request strobe, the selected channel, the local byte address, a flag marking the interleaved region and an out-of-range error. The decode is combinational. A parameter places a register stage at the output, and by default this adds one cycle of latency. The configuration is expected to stay steady while traffic flows. A request that falls beyond the installed memory raises the error and strobes no channel.

Top module: `ilv_chan_mapper`

## Requirements
- R1: With block index B = address bit 6 and above, and S = the smaller capacity in blocks, an address with B < 2*S is in the interleaved region: the interleaved flag is 1 and the selected channel equals address bit 6.
- R2: In the interleaved region, the local address is the input address with bit 6 removed: bits 5..0 are kept, and bits above 6 move down by one position.
- R3: An address with 2*S <= B < total capacity goes to the larger channel (channel 1 when cap1 > cap0, otherwise channel 0) with the flag 0, and its local address is the input address minus S*64.
- R4: When both capacities are equal, every in-range address is interleaved.
- R5: When one capacity is zero, every in-range address goes to the other channel, with the flag 0 and a local address equal to the input address.
- R6: An address with B >= cap0+cap1 raises the error output. Both request strobes stay 0 and the interleaved flag stays 0.
- R7: An in-range result raises exactly one request strobe, bit out_req[c] for the selected channel c.
- R8: With the default output register, each strobed request gives a result with out_valid high exactly one clock later. In a cycle with no result, out_valid, out_req and out_err are all 0.
- R9: During reset and after it, until the first strobe, out_valid, out_req and out_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap0_blk | input | 11 | Capacity of channel 0 in 64-byte blocks |
| cap1_blk | input | 11 | Capacity of channel 1 in 64-byte blocks |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 16 | Flat byte address |
| out_valid | output | 1 | Result strobe |
| out_req | output | 2 | Per-channel request strobe, bit c for channel c |
| out_ch | output | 1 | Selected channel |
| out_local | output | 16 | Channel-local byte address |
| out_ilv | output | 1 | Result lies in the interleaved region |
| out_err | output | 1 | Address beyond installed capacity |

## Verification
The mapper is driven with several capacity pairs: a larger channel 0, a larger channel 1, equal sizes, one channel empty, a single channel filling the whole space, and both channels empty. Each pair shows a different split between the interleaved, upper and out-of-range regions. Addresses sit on either side of each region limit: the last interleaved block against the first upper block, and the last byte of capacity against the first byte past it. These cases tell an off-by-one limit or a wrong local offset apart from a correct one. Random addresses under each pair, together with back-to-back and idle cycles, exercise the alternation on bit 6 and the one-cycle result timing.

// File: rtl/ilv_map_pkg.sv
package ilv_map_pkg;

  typedef enum logic [1:0] {
    RGN_ILV   = 2'd0,
    RGN_UPPER = 2'd1,
    RGN_OOR   = 2'd2
  } region_e;

endpackage

// File: rtl/ilv_rst_sync.sv
module ilv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/ilv_region_calc.sv
module ilv_region_calc #(
  parameter int CAP_W = 11,
  localparam int SUM_W = CAP_W + 1
) (
  input  logic [CAP_W-1:0] cap0_blk,
  input  logic [CAP_W-1:0] cap1_blk,
  output logic [CAP_W-1:0] small_blk,
  output logic [SUM_W-1:0] ilv_lim,
  output logic [SUM_W-1:0] total_blk,
  output logic             big_ch
);

  always_comb begin
    big_ch    = (cap1_blk > cap0_blk);
    small_blk = big_ch ? cap0_blk : cap1_blk;
    ilv_lim   = {small_blk, 1'b0};
    total_blk = SUM_W'(cap0_blk) + SUM_W'(cap1_blk);
  end

endmodule

// File: rtl/ilv_addr_decode.sv
module ilv_addr_decode
  import ilv_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GRAN   = 6,
  localparam int BLK_W = ADDR_W - GRAN,
  localparam int CAP_W = BLK_W + 1,
  localparam int SUM_W = CAP_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CAP_W-1:0]  small_blk,
  input  logic [SUM_W-1:0]  ilv_lim,
  input  logic [SUM_W-1:0]  total_blk,
  input  logic              big_ch,
  output region_e           region,
  output logic              ch,
  output logic [ADDR_W-1:0] local_addr
);

  logic [BLK_W-1:0] blk;
  logic [GRAN-1:0]  off;
  logic [SUM_W-1:0] blk_ext;
  logic [CAP_W-1:0] up_diff;
  logic [BLK_W-1:0] lblk;
  logic             diff_msb_unused;

  assign blk     = addr[ADDR_W-1:GRAN];
  assign off     = addr[GRAN-1:0];
  assign blk_ext = SUM_W'(blk);
  assign up_diff = CAP_W'(blk) - small_blk;
  assign diff_msb_unused = up_diff[CAP_W-1];

  always_comb begin
    if (blk_ext >= total_blk) begin
      region = RGN_OOR;
      ch     = 1'b0;
      lblk   = '0;
    end else if (blk_ext < ilv_lim) begin
      region = RGN_ILV;
      ch     = blk[0];
      lblk   = {1'b0, blk[BLK_W-1:1]};
    end else begin
      region = RGN_UPPER;
      ch     = big_ch;
      lblk   = up_diff[BLK_W-1:0];
    end
  end

  assign local_addr = {lblk, off};

endmodule

// File: rtl/ilv_out_stage.sv
module ilv_out_stage
  import ilv_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  region_e           region,
  input  logic              ch,
  input  logic [ADDR_W-1:0] local_addr,
  output logic              out_valid,
  output logic [NCH-1:0]    out_req,
  output logic              out_ch,
  output logic [ADDR_W-1:0] out_local,
  output logic              out_ilv,
  output logic              out_err
);

  logic              valid_d;
  logic [NCH-1:0]    req_d;
  logic              err_d;
  logic              ilv_d;
  logic              ch_d;
  logic [ADDR_W-1:0] local_d;

  always_comb begin
    valid_d = in_valid;
    err_d   = in_valid && (region == RGN_OOR);
    ilv_d   = (region == RGN_ILV);
    ch_d    = ch;
    local_d = local_addr;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_req
    assign req_d[c] = in_valid && (region != RGN_OOR) && (ch == 1'(c));
  end

  if (REG_OUT) begin : g_reg
    logic              valid_q;
    logic [NCH-1:0]    req_q;
    logic              err_q;
    logic              ilv_q;
    logic              ch_q;
    logic [ADDR_W-1:0] local_q;
    logic              data_en;

    assign data_en = in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        req_q   <= '0;
        err_q   <= 1'b0;
      end else begin
        valid_q <= valid_d;
        req_q   <= req_d;
        err_q   <= err_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ilv_q   <= 1'b0;
        ch_q    <= 1'b0;
        local_q <= '0;
      end else if (data_en) begin
        ilv_q   <= ilv_d;
        ch_q    <= ch_d;
        local_q <= local_d;
      end
    end

    assign out_valid = valid_q;
    assign out_req   = req_q;
    assign out_err   = err_q;
    assign out_ilv   = ilv_q;
    assign out_ch    = ch_q;
    assign out_local = local_q;
  end else begin : g_comb
    assign out_valid = valid_d && rst_n;
    assign out_req   = rst_n ? req_d : '0;
    assign out_err   = err_d && rst_n;
    assign out_ilv   = ilv_d && in_valid;
    assign out_ch    = ch_d;
    assign out_local = local_d;
  end

endmodule

// File: rtl/ilv_chan_mapper.sv
module ilv_chan_mapper
  import ilv_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int GRAN    = 6,
  parameter bit REG_OUT = 1'b1,
  localparam int BLK_W  = ADDR_W - GRAN,
  localparam int CAP_W  = BLK_W + 1,
  localparam int SUM_W  = CAP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAP_W-1:0]  cap0_blk,
  input  logic [CAP_W-1:0]  cap1_blk,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [1:0]        out_req,
  output logic              out_ch,
  output logic [ADDR_W-1:0] out_local,
  output logic              out_ilv,
  output logic              out_err
);

  logic              rst_sync_n;
  logic [CAP_W-1:0]  small_blk;
  logic [SUM_W-1:0]  ilv_lim;
  logic [SUM_W-1:0]  total_blk;
  logic              big_ch;
  region_e           region;
  logic              dec_ch;
  logic [ADDR_W-1:0] dec_local;

  ilv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ilv_region_calc #(.CAP_W(CAP_W)) u_rgn (
    .cap0_blk  (cap0_blk),
    .cap1_blk  (cap1_blk),
    .small_blk (small_blk),
    .ilv_lim   (ilv_lim),
    .total_blk (total_blk),
    .big_ch    (big_ch)
  );

  ilv_addr_decode #(.ADDR_W(ADDR_W), .GRAN(GRAN)) u_dec (
    .addr       (in_addr),
    .small_blk  (small_blk),
    .ilv_lim    (ilv_lim),
    .total_blk  (total_blk),
    .big_ch     (big_ch),
    .region     (region),
    .ch         (dec_ch),
    .local_addr (dec_local)
  );

  ilv_out_stage #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_valid   (in_valid),
    .region     (region),
    .ch         (dec_ch),
    .local_addr (dec_local),
    .out_valid  (out_valid),
    .out_req    (out_req),
    .out_ch     (out_ch),
    .out_local  (out_local),
    .out_ilv    (out_ilv),
    .out_err    (out_err)
  );

endmodule

// File: rtl/ilv_chan_mapper_chk.sv
module ilv_chan_mapper_chk #(
  parameter int ADDR_W  = 16,
  parameter int GRAN    = 6,
  parameter bit REG_OUT = 1'b1,
  localparam int CAP_W  = ADDR_W - GRAN + 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [CAP_W-1:0]  cap0_blk,
  input logic [CAP_W-1:0]  cap1_blk,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic [1:0]        out_req,
  input logic              out_ch,
  input logic [ADDR_W-1:0] out_local,
  input logic              out_ilv,
  input logic              out_err
);

  // R7
  p_req_onehot_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_err) |-> ($countones(out_req) == 1));

  p_req_sel_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_req != 2'b00) |-> out_req[out_ch]);

  // R6
  p_err_noreq_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_err |-> ((out_req == 2'b00) && !out_ilv));

  // R8
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> ((out_req == 2'b00) && !out_err));

  if (REG_OUT) begin : g_lat
    p_lat_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      in_valid |=> out_valid);

    // R1
    p_ilv_bit_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (out_valid && out_ilv) |-> (out_ch == $past(in_addr[GRAN])));

    // R2
    p_ilv_local_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (out_valid && out_ilv) |->
        (out_local == {1'b0, $past(in_addr[ADDR_W-1:GRAN+1]), $past(in_addr[GRAN-1:0])}));

    // R3
    p_upper_big_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (out_valid && !out_err && !out_ilv && ($past(cap0_blk) != $past(cap1_blk))) |->
        (out_ch == ($past(cap1_blk) > $past(cap0_blk))));

    // R4
    p_equal_ilv_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (out_valid && !out_err && ($past(cap0_blk) == $past(cap1_blk))) |-> out_ilv);
  end

endmodule

bind ilv_chan_mapper ilv_chan_mapper_chk #(
  .ADDR_W (ADDR_W),
  .GRAN   (GRAN),
  .REG_OUT(REG_OUT)
) chk_i (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .cap0_blk  (cap0_blk),
  .cap1_blk  (cap1_blk),
  .in_valid  (in_valid),
  .in_addr   (in_addr),
  .out_valid (out_valid),
  .out_req   (out_req),
  .out_ch    (out_ch),
  .out_local (out_local),
  .out_ilv   (out_ilv),
  .out_err   (out_err)
);

// File: tb/ilv_chan_mapper_tb_top.sv
module ilv_chan_mapper_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int GRAN   = 6;
  localparam int CAP_W  = ADDR_W - GRAN + 1;
  localparam int EXP_W  = ADDR_W + 3;

  logic              clk;
  logic              rst_n;
  logic [CAP_W-1:0]  cap0_blk;
  logic [CAP_W-1:0]  cap1_blk;
  logic              in_valid;
  logic [ADDR_W-1:0] in_addr;
  logic              out_valid;
  logic [1:0]        out_req;
  logic              out_ch;
  logic [ADDR_W-1:0] out_local;
  logic              out_ilv;
  logic              out_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [EXP_W-1:0] exp_q[$];
  string            tag_q[$];

  ilv_chan_mapper dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap0_blk (cap0_blk),
    .cap1_blk (cap1_blk),
    .in_valid (in_valid),
    .in_addr  (in_addr),
    .out_valid(out_valid),
    .out_req  (out_req),
    .out_ch   (out_ch),
    .out_local(out_local),
    .out_ilv  (out_ilv),
    .out_err  (out_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected item: {err, ilv, ch, local}
  function automatic logic [EXP_W-1:0] model(input logic [ADDR_W-1:0] a,
                                             input int c0, input int c1);
    int blk, s, tot, lblk;
    logic ch, ilv, err;
    blk = int'(a) / 64;
    s   = (c0 < c1) ? c0 : c1;
    tot = c0 + c1;
    err = 1'b0; ilv = 1'b0; ch = 1'b0; lblk = 0;
    if (blk >= tot) begin
      err = 1'b1;
    end else if (blk < 2 * s) begin
      ilv  = 1'b1;
      ch   = a[6];
      lblk = blk / 2;
    end else begin
      ch   = (c1 > c0);
      lblk = blk - s;
    end
    return {err, ilv, ch, ADDR_W'(lblk * 64 + (int'(a) % 64))};
  endfunction

  function automatic string auto_tag(input logic [EXP_W-1:0] e);
    if (e[EXP_W-1]) return "R6";
    if (e[EXP_W-2]) return "R1";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic cond, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_caps(input int c0, input int c1);
    @(negedge clk);
    in_valid = 1'b0;
    cap0_blk = CAP_W'(c0);
    cap1_blk = CAP_W'(c1);
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input string tag);
    logic [EXP_W-1:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    e = model(a, int'(cap0_blk), int'(cap1_blk));
    exp_q.push_back(e);
    tag_q.push_back((tag == "") ? auto_tag(e) : tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        check("R8", 1'b0, "unexpected out_valid", 1, 0);
      end else begin
        logic [EXP_W-1:0] e;
        string t;
        logic [1:0] er;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        er = e[EXP_W-1] ? 2'b00 : (e[ADDR_W] ? 2'b10 : 2'b01);
        check(t, out_err == e[EXP_W-1], "err", int'(out_err), int'(e[EXP_W-1]));
        check("R7", out_req == er, "req", int'(out_req), int'(er));
        check(t, out_ilv == e[EXP_W-2], "ilv", int'(out_ilv), int'(e[EXP_W-2]));
        if (!e[EXP_W-1]) begin
          check(t, out_ch == e[ADDR_W], "ch", int'(out_ch), int'(e[ADDR_W]));
          check(t, out_local == e[ADDR_W-1:0], "local", int'(out_local),
                int'(e[ADDR_W-1:0]));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_addr  = '0;
    cap0_blk = CAP_W'(512);
    cap1_blk = CAP_W'(256);
    repeat (3) @(negedge clk);
    check("R9", !out_valid && out_req == 2'b00 && !out_err, "reset outputs",
          int'({out_valid, out_req, out_err}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9", !out_valid && out_req == 2'b00 && !out_err, "after reset",
          int'({out_valid, out_req, out_err}), 0);

    // larger channel 0: 512 / 256 blocks
    set_caps(512, 256);
    send(16'h0000, "R1");
    send(16'h0040, "R1");
    send(16'h0085, "R2");
    send(16'h7FFF, "R2");
    send(16'h8000, "R3");
    send(16'hBFFF, "R3");
    send(16'hC000, "R6");
    send(16'hFFFF, "R6");
    idle(2);
    check("R8", !out_valid && out_req == 2'b00 && !out_err, "idle outputs",
          int'({out_valid, out_req, out_err}), 0);

    // larger channel 1
    set_caps(256, 512);
    send(16'h7FC0, "R1");
    send(16'h8000, "R3");
    send(16'hBFC1, "R3");
    send(16'hC000, "R6");

    // equal
    set_caps(512, 512);
    send(16'h0000, "R4");
    send(16'h0041, "R4");
    send(16'hFFFF, "R4");
    send(16'h8040, "R4");

    // one channel empty
    set_caps(0, 600);
    send(16'h1234, "R5");
    send(16'h0040, "R5");
    send(16'h95FF, "R5");
    send(16'h9600, "R6");
    set_caps(1024, 0);
    send(16'hFFFF, "R5");
    send(16'h4567, "R5");

    // both empty
    set_caps(0, 0);
    send(16'h0000, "R6");

    // random under several pairs
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: set_caps(512, 256);
        1: set_caps(100, 700);
        2: set_caps(300, 300);
        3: set_caps(0, 1000);
        4: set_caps(777, 33);
        default: set_caps(1024, 1024);
      endcase
      for (int i = 0; i < 200; i++) begin
        send(ADDR_W'($urandom), "");
        if ((i % 17) == 0) idle(1);
      end
    end
    idle(3);
    check("R8", exp_q.size() == 0, "results outstanding", exp_q.size(), 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule